// File: doc/BRIEF.md
# Clock-Loss Watchdog Reset Generator

This block guards logic that runs on a clock arriving from off the chip, for example the clock of an external bus bridge. That clock can stop without warning: the cable is pulled, or the bridge powers down. When it stops, the logic on it freezes mid-transfer and cannot be reset in the normal way. The block drives a reset for that foreign domain that asserts either on the normal system reset or when the foreign clock is found to have stopped.

A heartbeat flop on the foreign clock flips on every rising edge. A free-running system clock samples the heartbeat through a two-stage synchroniser. A timeout counter restarts at every heartbeat change it sees. The monitor is a two-state machine:

- `WD_RUN` moves to `WD_LOST` when the counter has saturated at all ones and no heartbeat change arrives.
- `WD_LOST` moves back to `WD_RUN` on the first heartbeat change.

While in `WD_LOST`, the status flag `clk_lost` is high. It is ANDed (active low) with the system reset into a reset request. A reset synchroniser in the foreign domain turns that request into `mon_rst_n`. This reset asserts at once, with no clock needed, and releases on the second foreign-clock edge after the request clears.

Top module: `clk_watchdog_reset`

## Requirements
- R1: While `sys_rst_n` is low, `clk_lost` is 0 and `mon_rst_n` is 0. This holds whether the foreign clock is running or stopped.
- R2: After the reset request clears, `mon_rst_n` is still 0 after the first rising edge of `mon_clk` and is 1 after the second.
- R3: While `mon_clk` keeps running, `clk_lost` stays 0 and `mon_rst_n` stays 1. This holds whether the foreign clock is faster or slower than `sys_clk`.
- R4: When `mon_clk` stops, `clk_lost` stays 0 for at least 2^TIMEOUT_W − 4 `sys_clk` cycles. It becomes 1 within 2^TIMEOUT_W + 8 cycles.
- R5: While `clk_lost` is 1, `mon_rst_n` is 0, even though `mon_clk` gives no edges.
- R6: When `mon_clk` restarts, `clk_lost` returns to 0 within a few `sys_clk` cycles (`WD_LOST` to `WD_RUN`). `mon_rst_n` then releases per R2.
- R7: While `mon_clk` stays stopped, `clk_lost` stays 1 indefinitely. The counter saturates and does not wrap.
- R8: Asserting `sys_rst_n` during a loss clears `clk_lost` at once. After release, the timeout starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Free-running monitoring clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset |
| mon_clk | input | 1 | Foreign clock being watched |
| mon_rst_n | output | 1 | Active-low effective reset for the foreign domain |
| clk_lost | output | 1 | High while the foreign clock is judged stopped (sys_clk domain) |

## Verification
The bench stops the foreign clock and probes both sides of the timeout window. A design that counted from the wrong point, or whose counter wrapped, would flag too early or drop the flag again after a while. The bench also checks that the foreign reset drops while no foreign edge exists. A synchronously asserted reset would stay high and leave the protocol logic frozen. Recovery is run after a system reset taken mid-loss. A heartbeat held in reset by the effective reset itself would never toggle again and deadlock the block. A reset synchroniser one stage short would release on the first foreign edge.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
    // Monitor states for the timeout machine
    typedef enum logic [0:0] {
        WD_RUN  = 1'b0,
        WD_LOST = 1'b1
    } wd_state_t;
endpackage

// File: rtl/cwd_heartbeat.sv
// Toggle flop in the watched domain. Its reset comes from the plain system
// reset, never from the effective reset, so it resumes as soon as edges return.
module cwd_heartbeat (
    input  logic mon_clk,
    input  logic arst_n,
    output logic beat
);
    always_ff @(posedge mon_clk or negedge arst_n) begin
        if (!arst_n) beat <= 1'b0;
        else         beat <= ~beat;
    end
endmodule

// File: rtl/cwd_sync2.sv
// Two-stage capture chain. Both flops take a signal that is asynchronous to
// clk and must be kept adjacent, with no logic between them.
module cwd_sync2 #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta <= RESET_VAL;
            q    <= RESET_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cwd_timeout.sv
module cwd_timeout
    import cwd_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_sync,
    output logic lost
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    wd_state_t        state, nxt;
    logic             hb_prev;
    logic             hb_edge;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hb_prev <= 1'b0;
        else        hb_prev <= hb_sync;
    end

    assign hb_edge = hb_sync ^ hb_prev;

    // Silence counter: reloads on a heartbeat change, saturates at all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (hb_edge)         cnt <= '0;
        else if (cnt != CNT_MAX)  cnt <= cnt + 1'b1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_RUN;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            WD_RUN:  if (!hb_edge && cnt == CNT_MAX) nxt = WD_LOST;
            WD_LOST: if (hb_edge)                    nxt = WD_RUN;
            default: nxt = WD_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        lost = (state == WD_LOST);
    end

    // R4
    lost_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> ($past(cnt) == CNT_MAX));

    // R6
    lost_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && hb_edge) |=> !lost);

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !hb_edge) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/clk_watchdog_reset.sv
module clk_watchdog_reset #(
    parameter int TIMEOUT_W = 16
) (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic mon_clk,
    output logic mon_rst_n,
    output logic clk_lost
);
    logic beat;
    logic beat_sync;
    logic rst_req_n;

    cwd_heartbeat u_beat (
        .mon_clk (mon_clk),
        .arst_n  (sys_rst_n),
        .beat    (beat)
    );

    cwd_sync2 #(.RESET_VAL(1'b0)) u_beat_sync (
        .clk    (sys_clk),
        .arst_n (sys_rst_n),
        .d      (beat),
        .q      (beat_sync)
    );

    cwd_timeout #(.CNT_W(TIMEOUT_W)) u_timeout (
        .clk     (sys_clk),
        .rst_n   (sys_rst_n),
        .hb_sync (beat_sync),
        .lost    (clk_lost)
    );

    // Request is low on system reset or on a detected loss; both terms are
    // flop outputs or a primary reset, so the gate adds no new glitch source.
    assign rst_req_n = sys_rst_n & ~clk_lost;

    // Assert without a clock, release after two foreign edges
    cwd_sync2 #(.RESET_VAL(1'b0)) u_rst_sync (
        .clk    (mon_clk),
        .arst_n (rst_req_n),
        .d      (1'b1),
        .q      (mon_rst_n)
    );

    // R5
    lost_holds_reset_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        clk_lost |-> !mon_rst_n);

    // R2
    mon_release_chk: assert property (@(posedge mon_clk) disable iff (!rst_req_n)
        $rose(mon_rst_n) |-> $past(rst_req_n));
endmodule

// File: tb/clk_watchdog_reset_test.sv
module clk_watchdog_reset_test;
    localparam int CLK_PERIOD = 10;
    localparam int TW         = 6;
    localparam int MAXC       = (1 << TW) - 1;

    logic sys_clk   = 1'b0;
    logic sys_rst_n = 1'b1;
    logic mon_clk   = 1'b0;
    logic mon_run   = 1'b0;
    int   mon_half  = 7;
    logic mon_rst_n;
    logic clk_lost;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    clk_watchdog_reset #(.TIMEOUT_W(TW)) uut (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .mon_clk   (mon_clk),
        .mon_rst_n (mon_rst_n),
        .clk_lost  (clk_lost)
    );

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    always begin
        if (mon_run) #(mon_half) mon_clk = ~mon_clk;
        else         #1;
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic sys_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge sys_clk);
    endtask

    task automatic t_reset;
        #1 sys_rst_n = 1'b0;
        #20;
        chk("R1", "mon_rst_n, clock stopped", mon_rst_n, 1'b0);
        chk("R1", "clk_lost in reset", clk_lost, 1'b0);
        mon_half = 7;
        mon_run  = 1'b1;
        for (int i = 0; i < 4; i++) @(posedge mon_clk);
        #1;
        chk("R1", "mon_rst_n, clock running", mon_rst_n, 1'b0);
        @(negedge mon_clk);
        #1 sys_rst_n = 1'b1;
        @(posedge mon_clk); #1;
        chk("R2", "after first edge", mon_rst_n, 1'b0);
        @(posedge mon_clk); #1;
        chk("R2", "after second edge", mon_rst_n, 1'b1);
    endtask

    task automatic t_running;
        int halves [3] = '{7, 2, 13};
        foreach (halves[k]) begin
            logic any_lost = 1'b0;
            logic any_rst  = 1'b0;
            mon_half = halves[k];
            for (int i = 0; i < 3*MAXC; i++) begin
                @(negedge sys_clk);
                if (clk_lost !== 1'b0) any_lost = 1'b1;
                if (mon_rst_n !== 1'b1) any_rst = 1'b1;
            end
            chk("R3", $sformatf("no loss, half=%0d", halves[k]), any_lost, 1'b0);
            chk("R3", $sformatf("reset held off, half=%0d", halves[k]), any_rst, 1'b0);
        end
        mon_half = 7;
        sys_cycles(5);
    endtask

    task automatic t_stop;
        @(negedge sys_clk);
        mon_run = 1'b0;
        sys_cycles(MAXC - 4);
        chk("R4", "not yet lost", clk_lost, 1'b0);
        sys_cycles(12);
        chk("R4", "lost after timeout", clk_lost, 1'b1);
        chk("R5", "reset asserted without clock", mon_rst_n, 1'b0);
        sys_cycles(3*MAXC);
        chk("R7", "loss held", clk_lost, 1'b1);
        chk("R7", "reset still held", mon_rst_n, 1'b0);
    endtask

    task automatic t_sysrst;
        @(negedge sys_clk);
        sys_rst_n = 1'b0;
        #1;
        chk("R8", "loss cleared by reset", clk_lost, 1'b0);
        chk("R8", "foreign reset held", mon_rst_n, 1'b0);
        sys_cycles(3);
        sys_rst_n = 1'b1;
        sys_cycles(MAXC - 6);
        chk("R8", "timeout restarted", clk_lost, 1'b0);
        sys_cycles(12);
        chk("R8", "loss again after full timeout", clk_lost, 1'b1);
    endtask

    task automatic t_recover;
        logic cleared = 1'b0;
        mon_half = 7;
        mon_run  = 1'b1;
        for (int i = 0; i < 20 && !cleared; i++) begin
            @(negedge sys_clk);
            if (clk_lost === 1'b0) cleared = 1'b1;
        end
        chk("R6", "loss clears on restart", cleared, 1'b1);
        chk("R6", "reset not yet released", mon_rst_n, 1'b0);
        @(posedge mon_clk);
        @(posedge mon_clk); #1;
        chk("R6", "reset released after sync", mon_rst_n, 1'b1);
        sys_cycles(2*MAXC);
        chk("R6", "stays recovered", clk_lost, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_running();
        t_stop();
        t_sysrst();
        t_recover();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule